// File: doc/BRIEF.md
# Framed Burst Bit-Error Counter

This block measures bit errors for one burst of a test link. A start pulse arms it with three settings: the frame length in bits, the number of leading preamble bits, and a sample offset. The block then watches a stream of recovered bits that arrives with a valid strobe, together with the expected reference bit for each sample. The first offset-many valid samples are thrown away. Decisions begin at that fixed sample index, so no synchronisation search takes place. Every valid sample after that point is compared with its reference bit, until the programmed number of bits has been compared.

Three counters come out of a run. The first counts the received bits. The second counts every mismatch in the frame. The third counts only the mismatches that fall after the preamble. Busy is high while the run is in progress, and a one-cycle done pulse marks the end. The counters keep their values until the next start. Demodulation, generation of the reference sequence and any register access sit outside this block.

Top module: `ber_burst_counter`

## Requirements
- R1: After reset, busy_o and done_o are 0 and all three counts are 0.
- R2: A start pulse accepted while idle clears all three counts. With a nonzero frame length, busy_o is 1 in the following cycle.
- R3: The first start_ofs valid samples of a run are discarded. They change no count, even when the bits mismatch.
- R4: After the discarded samples, each cycle with smp_valid_i high adds exactly one to rx_count_o. Cycles with smp_valid_i low change no count.
- R5: tot_err_o counts every compared sample where rx_bit_i differs from ref_bit_i, preamble bits included.
- R6: pay_err_o counts mismatches only at bit index k >= preamble_len, where the first compared bit has k = 0. When preamble_len >= frame_len, pay_err_o stays 0.
- R7: Busy stays 1 until frame_len bits have been compared. In the cycle after the last comparison, busy_o is 0, done_o is 1 for exactly one cycle and rx_count_o equals frame_len. The counts then hold until the next accepted start.
- R8: A start with frame_len = 0 never raises busy_o. It pulses done_o in the next cycle with all counts at 0.
- R9: A start pulse that arrives while busy_o is 1 is ignored.
- R10: The three settings are captured on the accepted start. Changing the setting inputs during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Run start pulse |
| frame_len_i | input | LEN_W | Bits to compare in the run |
| preamble_len_i | input | LEN_W | Leading bits excluded from the payload error count |
| start_ofs_i | input | OFS_W | Valid samples to discard before the first decision |
| smp_valid_i | input | 1 | Sample strobe for rx_bit_i and ref_bit_i |
| rx_bit_i | input | 1 | Recovered bit |
| ref_bit_i | input | 1 | Reference bit for the same sample |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| rx_count_o | output | LEN_W | Bits compared |
| tot_err_o | output | LEN_W | Mismatches over the whole frame |
| pay_err_o | output | LEN_W | Mismatches over the payload only |

## Verification
The assertions assume that start pulses never come during the two cycles while the internal reset is still held. They also assume the frame length fits the counter width, so no count can wrap. The stimulus waits several cycles after reset before its first start, and every programmed frame is far below the counter limit. The stimulus also inserts gaps in the valid strobe, drives mismatching bits during the discard phase and during gaps, and changes the setting inputs during every run. A correct design therefore must ignore all of these, and the assertions on count steps and ordering hold under this stimulus.

// File: rtl/ber_pkg.sv
package ber_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SKIP = 2'd1,
    ST_CMP  = 2'd2
  } run_state_e;

  localparam int CNT_RX  = 0;
  localparam int CNT_TOT = 1;
  localparam int CNT_PAY = 2;
  localparam int N_CNT   = 3;
endpackage

// File: rtl/ber_rst_sync.sv
module ber_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ber_run_ctrl.sv
module ber_run_ctrl
  import ber_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [LEN_W-1:0] preamble_len_i,
  input  logic [OFS_W-1:0] start_ofs_i,
  input  logic             smp_valid_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             clear_o,
  output logic             cmp_en_o,
  output logic             payload_o,
  output logic [LEN_W-1:0] frame_len_o
);
  run_state_e       state_q, state_n;
  logic             done_q, done_n;
  logic [LEN_W-1:0] frame_q, pre_q;
  logic [OFS_W-1:0] ofs_q;
  logic [OFS_W-1:0] skip_q, skip_n;
  logic [LEN_W-1:0] bit_q, bit_n;
  logic             accept, cfg_en, skip_en, bit_en;
  logic             skip_last, bit_last;

  assign accept    = start_i && (state_q == ST_IDLE);
  assign cfg_en    = accept;
  assign skip_last = (OFS_W'(skip_q + 1'b1) == ofs_q);
  assign bit_last  = (LEN_W'(bit_q + 1'b1) == frame_q);

  // next-state logic
  always_comb begin
    state_n = state_q;
    done_n  = 1'b0;
    skip_n  = skip_q;
    bit_n   = bit_q;
    skip_en = 1'b0;
    bit_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          skip_en = 1'b1;
          bit_en  = 1'b1;
          skip_n  = '0;
          bit_n   = '0;
          if (frame_len_i == '0) begin
            done_n = 1'b1;
          end else if (start_ofs_i == '0) begin
            state_n = ST_CMP;
          end else begin
            state_n = ST_SKIP;
          end
        end
      end
      ST_SKIP: begin
        if (smp_valid_i) begin
          skip_en = 1'b1;
          skip_n  = OFS_W'(skip_q + 1'b1);
          if (skip_last) state_n = ST_CMP;
        end
      end
      ST_CMP: begin
        if (smp_valid_i) begin
          bit_en = 1'b1;
          bit_n  = LEN_W'(bit_q + 1'b1);
          if (bit_last) begin
            state_n = ST_IDLE;
            done_n  = 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      pre_q   <= '0;
      ofs_q   <= '0;
    end else if (cfg_en) begin
      frame_q <= frame_len_i;
      pre_q   <= preamble_len_i;
      ofs_q   <= start_ofs_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       skip_q <= '0;
    else if (skip_en) skip_q <= skip_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bit_q <= '0;
    else if (bit_en) bit_q <= bit_n;
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign clear_o     = accept;
  assign cmp_en_o    = (state_q == ST_CMP) && smp_valid_i;
  assign payload_o   = (bit_q >= pre_q);
  assign frame_len_o = frame_q;
endmodule

// File: rtl/ber_err_counters.sv
module ber_err_counters
  import ber_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear_i,
  input  logic                        cmp_en_i,
  input  logic                        mismatch_i,
  input  logic                        payload_i,
  output logic [N_CNT-1:0][LEN_W-1:0] count_o
);
  logic [N_CNT-1:0] inc;

  always_comb begin
    inc          = '0;
    inc[CNT_RX]  = cmp_en_i;
    inc[CNT_TOT] = cmp_en_i && mismatch_i;
    inc[CNT_PAY] = cmp_en_i && mismatch_i && payload_i;
  end

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
    logic [LEN_W-1:0] cnt_q, cnt_n;
    logic             cnt_en;

    assign cnt_en = clear_i || inc[gi];

    always_comb begin
      if (clear_i) cnt_n = '0;
      else         cnt_n = LEN_W'(cnt_q + 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_n;
    end

    assign count_o[gi] = cnt_q;
  end
endmodule

// File: rtl/ber_burst_counter.sv
module ber_burst_counter
  import ber_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [LEN_W-1:0] preamble_len_i,
  input  logic [OFS_W-1:0] start_ofs_i,
  input  logic             smp_valid_i,
  input  logic             rx_bit_i,
  input  logic             ref_bit_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [LEN_W-1:0] rx_count_o,
  output logic [LEN_W-1:0] tot_err_o,
  output logic [LEN_W-1:0] pay_err_o
);
  logic                        rst_sync_n;
  logic                        clear, cmp_en, payload, mismatch;
  logic [LEN_W-1:0]            cfg_frame_len;
  logic [N_CNT-1:0][LEN_W-1:0] counts;

  ber_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ber_run_ctrl #(.LEN_W(LEN_W), .OFS_W(OFS_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .start_i        (start_i),
    .frame_len_i    (frame_len_i),
    .preamble_len_i (preamble_len_i),
    .start_ofs_i    (start_ofs_i),
    .smp_valid_i    (smp_valid_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .clear_o        (clear),
    .cmp_en_o       (cmp_en),
    .payload_o      (payload),
    .frame_len_o    (cfg_frame_len)
  );

  assign mismatch = rx_bit_i ^ ref_bit_i;

  ber_err_counters #(.LEN_W(LEN_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clear_i    (clear),
    .cmp_en_i   (cmp_en),
    .mismatch_i (mismatch),
    .payload_i  (payload),
    .count_o    (counts)
  );

  assign rx_count_o = counts[CNT_RX];
  assign tot_err_o  = counts[CNT_TOT];
  assign pay_err_o  = counts[CNT_PAY];
endmodule

// File: rtl/ber_burst_counter_chk.sv
module ber_burst_counter_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [LEN_W-1:0] rx_count_o,
  input logic [LEN_W-1:0] tot_err_o,
  input logic [LEN_W-1:0] pay_err_o,
  input logic [LEN_W-1:0] cfg_frame_len
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (rx_count_o == '0 && tot_err_o == '0 && pay_err_o == '0)); // R2

  AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (rx_count_o == $past(rx_count_o)) ||
               (rx_count_o == LEN_W'($past(rx_count_o) + 1'b1))); // R4

  AST_RX_BELOW_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rx_count_o < cfg_frame_len)); // R7

  AST_TOT_LE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    tot_err_o <= rx_count_o); // R5

  AST_PAY_LE_TOT: assert property (@(posedge clk) disable iff (!rst_n)
    pay_err_o <= tot_err_o); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && rx_count_o == cfg_frame_len)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(rx_count_o) && $stable(tot_err_o) && $stable(pay_err_o))); // R7

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && rx_count_o != '0) |=> (rx_count_o != '0)); // R9
endmodule

bind ber_burst_counter ber_burst_counter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .rx_count_o    (rx_count_o),
  .tot_err_o     (tot_err_o),
  .pay_err_o     (pay_err_o),
  .cfg_frame_len (cfg_frame_len)
);

// File: tb/ber_burst_counter_test.sv
module ber_burst_counter_test;
  localparam int LEN_W = 16;
  localparam int OFS_W = 12;
  localparam int NV    = 6;

  // per run: frame, preamble, offset, gap modulus, error mask, restart poke index
  localparam int V_FRAME [NV] = '{20, 40, 33,  1, 50, 25};
  localparam int V_PRE   [NV] = '{ 4,  8, 33,  0,  0, 40};
  localparam int V_OFS   [NV] = '{ 3,  0,  5,  0, 17,  2};
  localparam int V_GAP   [NV] = '{ 0,  3,  4,  0,  5,  0};
  localparam int V_MASK  [NV] = '{16'h0000, 16'h8421, 16'hFFFF, 16'h0001, 16'h0F0F, 16'h00FF};
  localparam int V_POKE  [NV] = '{-1, 12, -1, -1, 30, -1};

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [LEN_W-1:0] frame_len_i, preamble_len_i;
  logic [OFS_W-1:0] start_ofs_i;
  logic             smp_valid_i, rx_bit_i, ref_bit_i;
  logic             busy_o, done_o;
  logic [LEN_W-1:0] rx_count_o, tot_err_o, pay_err_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ber_burst_counter #(.LEN_W(LEN_W), .OFS_W(OFS_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_len_i(frame_len_i),
    .preamble_len_i(preamble_len_i), .start_ofs_i(start_ofs_i),
    .smp_valid_i(smp_valid_i), .rx_bit_i(rx_bit_i), .ref_bit_i(ref_bit_i),
    .busy_o(busy_o), .done_o(done_o), .rx_count_o(rx_count_o),
    .tot_err_o(tot_err_o), .pay_err_o(pay_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic ref_of(input int n);
    ref_of = n[0] ^ n[2] ^ n[3] ^ n[5];
  endfunction

  task automatic run_burst(input int frame, input int pre, input int ofs,
                           input int gap, input int mask, input int poke);
    int sent, k, etot, epay, busy_bad;
    bit r3_done;
    etot = 0; epay = 0;
    for (int b = 0; b < frame; b++) begin
      if (mask[b % 16]) begin
        etot++;
        if (b >= pre) epay++;
      end
    end
    @(negedge clk);
    start_i = 1'b1;
    frame_len_i = LEN_W'(frame); preamble_len_i = LEN_W'(pre); start_ofs_i = OFS_W'(ofs);
    smp_valid_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    // R10: disturb the setting inputs for the rest of the run
    frame_len_i = 16'd3; preamble_len_i = 16'd0; start_ofs_i = '0;
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    chk(rx_count_o == 0 && tot_err_o == 0 && pay_err_o == 0, "R2 counts cleared",
        rx_count_o + tot_err_o + pay_err_o, 0);
    sent = 0; k = 0; busy_bad = 0; r3_done = 0;
    while (sent < ofs + frame) begin
      if (!busy_o) busy_bad++;
      if (sent == ofs && ofs > 0 && !r3_done) begin
        r3_done = 1;
        chk(rx_count_o == 0 && tot_err_o == 0, "R3 discarded samples", rx_count_o + tot_err_o, 0);
      end
      start_i = (k == poke);  // R9 restart attempt while busy
      if (k == poke) frame_len_i = '0;
      ref_bit_i = ref_of(sent);
      if (gap != 0 && (k % gap) == gap - 1) begin
        smp_valid_i = 1'b0;
        rx_bit_i = ~ref_bit_i;  // R4 ignored while not valid
      end else begin
        smp_valid_i = 1'b1;
        if (sent < ofs) rx_bit_i = ~ref_bit_i;
        else rx_bit_i = ref_bit_i ^ mask[(sent - ofs) % 16];
        sent++;
      end
      k++;
      @(negedge clk);
      start_i = 1'b0;
    end
    smp_valid_i = 1'b0;
    chk(busy_bad == 0, "R7 busy held during run", busy_bad, 0);
    chk(done_o == 1'b1 && busy_o == 1'b0, "R7 done with busy low", {busy_o, done_o}, 1);
    chk(rx_count_o == frame, "R4 received count", rx_count_o, frame);
    chk(tot_err_o == etot, "R5 total errors", tot_err_o, etot);
    chk(pay_err_o == epay, "R6 payload errors", pay_err_o, epay);
    if (poke >= 0) chk(rx_count_o == frame, "R9 start ignored while busy", rx_count_o, frame);
    chk(rx_count_o == frame, "R10 settings latched at start", rx_count_o, frame);
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R7 done lasts one cycle", done_o, 0);
    chk(rx_count_o == frame && tot_err_o == etot && pay_err_o == epay, "R7 counts hold",
        tot_err_o, etot);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; frame_len_i = '0; preamble_len_i = '0; start_ofs_i = '0;
    smp_valid_i = 1'b0; rx_bit_i = 1'b0; ref_bit_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
    chk(rx_count_o == 0, "R1 rx count after reset", rx_count_o, 0);
    chk(tot_err_o == 0, "R1 total after reset", tot_err_o, 0);
    chk(pay_err_o == 0, "R1 payload after reset", pay_err_o, 0);

    for (int v = 0; v < NV; v++)
      run_burst(V_FRAME[v], V_PRE[v], V_OFS[v], V_GAP[v], V_MASK[v], V_POKE[v]);

    // R8: zero-length frame after a run that left nonzero counts
    @(negedge clk);
    start_i = 1'b1; frame_len_i = '0; preamble_len_i = 16'd2; start_ofs_i = 12'd4;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b1 && busy_o == 1'b0, "R8 zero frame done without busy", {busy_o, done_o}, 1);
    chk(rx_count_o == 0 && tot_err_o == 0 && pay_err_o == 0, "R8 zero frame counts",
        rx_count_o + tot_err_o + pay_err_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R8 zero frame pulse ends", {busy_o, done_o}, 0);

    // R4: valid samples while idle change nothing
    smp_valid_i = 1'b1; rx_bit_i = 1'b1; ref_bit_i = 1'b0;
    repeat (5) @(negedge clk);
    smp_valid_i = 1'b0;
    chk(rx_count_o == 0 && tot_err_o == 0 && busy_o == 1'b0, "R4 idle samples ignored",
        rx_count_o + tot_err_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule